// File: doc/BRIEF.md
# Flash Write Protection Gate

This block sits behind the command decoder of a serial non-volatile memory. Each decoded command is presented with a one-cycle valid strobe. One cycle later the gate answers with either an accept pulse or a reject pulse. An accepted command may then start its program, erase or status-write engine. A rejected one has no effect.

The gate combines several safeguards against unintended writes:
- **Power-up lockout.** While the supply is not good, the whole gate is held in reset. After the supply becomes good, a lockout window of programmable length blocks every command that could modify the array or the status register.
- **Write-enable latch.** The latch must be set by a write-enable command before each modifying command. It clears itself when the running engine reports completion.
- **Status-register lock.** The status-register protect bits, combined with the write-protect pin, decide whether the protect bits may be rewritten.
- **Power-down mode.** In power-down only the release command is honoured.

The gate also holds those protect bits. The bits are loaded when a status-write command is accepted.

Top module: `fwp_gate`

## Requirements
- R1: While `rst` is high or `supply_ok` is low, no accept or reject pulse is produced. One cycle after either condition is seen, `wel`, `pwr_down` and `stat_prot` are 0, and the lockout window restarts.
- R2: The lockout window covers the first LOCK_CYCLES commands after reset is released, counted as the first LOCK_CYCLES clock edges at which reset is low. During the window, write-enable, page-program, the three erase commands and status-write are rejected. All other commands are decided as usual.
- R3: `wel` is 0 after reset. An accepted write-enable command sets `wel` one cycle later.
- R4: Page-program, sector-erase, block-erase, chip-erase and status-write are rejected whenever `wel` is 0.
- R5: A pulse on `done_prog`, `done_erase` or `done_stat` clears `wel` on the next cycle. The exception is a write-enable command accepted in the same cycle, which leaves `wel` at 1.
- R6: A write-disable command clears `wel` and is accepted in any state except power-down, including during the lockout window.
- R7: An accepted power-down command sets `pwr_down`. While `pwr_down` is 1, every command except release-power-down is rejected and changes no state. Release-power-down clears `pwr_down`; outside power-down it is accepted with no effect.
- R8: A status-write is rejected when `stat_prot[BP_W+1:BP_W]` is 2'b1x. It is also rejected when that field is 2'b01 and `wp_n` is 0. It is permitted when the field is 2'b00.
- R9: An accepted status-write loads `stat_prot` with `stat_wdata` one cycle later. The two top bits form the lock field decoded by R8.
- R10: Each valid command produces exactly one of `cmd_accept` or `cmd_reject`, as a one-cycle pulse on the following cycle. No pulse appears without a command. A rejected command leaves `wel`, `pwr_down` and `stat_prot` unchanged.
- R11: The command codes are:
  - 1: write-enable
  - 2: write-disable
  - 3: page-program
  - 4: sector-erase
  - 5: block-erase
  - 6: chip-erase
  - 7: status-write
  - 8: status-read
  - 9: data-read
  - 10: power-down
  - 11: release-power-down

  Codes 0 and 12 to 15 are rejected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| supply_ok | input | 1 | Supply-good level; low holds the gate in reset |
| wp_n | input | 1 | Write-protect pin, active low |
| cmd_valid | input | 1 | One-cycle strobe for `cmd_code` |
| cmd_code | input | 4 | Decoded command code (R11) |
| stat_wdata | input | BP_W+2 | New protect bits carried by a status-write |
| done_prog | input | 1 | Program engine completion pulse |
| done_erase | input | 1 | Erase engine completion pulse |
| done_stat | input | 1 | Status-write engine completion pulse |
| cmd_accept | output | 1 | Command accepted, one cycle after the strobe |
| cmd_reject | output | 1 | Command rejected, one cycle after the strobe |
| wel | output | 1 | Write-enable latch |
| pwr_down | output | 1 | Power-down state |
| stat_prot | output | BP_W+2 | Protect bits: lock field on top, block-protect bits below |

## Verification
The assertions take the following for granted:
- `rst` and `supply_ok` are synchronous levels.
- Completion pulses arrive one cycle wide.
- At most one command is presented per cycle.
- No input changes near the sampling edge.

The stimulus keeps within these assumptions. Every input is driven at the falling clock edge, and each command strobe and completion pulse lasts exactly one cycle. Each command's verdict and the resulting latch, power-down and status state are compared against an arithmetic model. The sweep covers every code under every combination of lock field, write-protect pin level and latch value, plus separate runs through the lockout window and the power-down mode.

// File: rtl/fwp_pkg.sv
package fwp_pkg;

    localparam int CMD_W = 4;

    typedef enum logic [CMD_W-1:0] {
        CMD_NONE    = 4'd0,
        CMD_WREN    = 4'd1,
        CMD_WRDI    = 4'd2,
        CMD_PROG    = 4'd3,
        CMD_SECT_ER = 4'd4,
        CMD_BLK_ER  = 4'd5,
        CMD_CHIP_ER = 4'd6,
        CMD_WR_STAT = 4'd7,
        CMD_RD_STAT = 4'd8,
        CMD_READ    = 4'd9,
        CMD_PWR_DN  = 4'd10,
        CMD_PWR_UP  = 4'd11
    } cmd_e;

    typedef struct packed {
        logic accept;
        logic reject;
        logic set_wel;
        logic clr_wel;
        logic enter_pd;
        logic leave_pd;
        logic load_stat;
    } verdict_t;

    // Commands held off during the power-up lockout window.
    function automatic logic is_modifying(logic [CMD_W-1:0] c);
        return (c == CMD_WREN) || (c == CMD_PROG) || (c == CMD_SECT_ER) ||
               (c == CMD_BLK_ER) || (c == CMD_CHIP_ER) || (c == CMD_WR_STAT);
    endfunction

    // Commands that require the write-enable latch.
    function automatic logic needs_wel(logic [CMD_W-1:0] c);
        return (c == CMD_PROG) || (c == CMD_SECT_ER) || (c == CMD_BLK_ER) ||
               (c == CMD_CHIP_ER) || (c == CMD_WR_STAT);
    endfunction

    function automatic logic is_known(logic [CMD_W-1:0] c);
        return (c >= CMD_WREN) && (c <= CMD_PWR_UP);
    endfunction

    // Lock field: 00 open, 01 locked while pin low, 1x locked until power cycle.
    function automatic logic lock_open(logic [1:0] lock_fld, logic pin_n);
        return (lock_fld == 2'b00) || ((lock_fld == 2'b01) && pin_n);
    endfunction

endpackage

// File: rtl/fwp_lockout.sv
module fwp_lockout #(
    parameter int LOCK_CYCLES = 2000
) (
    input  logic clk,
    input  logic hold,
    output logic busy
);
    localparam int CW = $clog2(LOCK_CYCLES + 1);

    logic [CW-1:0] remain;

    always_ff @(posedge clk) begin
        if (hold)
            remain <= CW'(LOCK_CYCLES);
        else if (remain != '0)
            remain <= remain - CW'(1);
    end

    assign busy = (remain != '0);
endmodule

// File: rtl/fwp_wel.sv
module fwp_wel (
    input  logic clk,
    input  logic hold,
    input  logic set_req,
    input  logic clr_req,
    input  logic op_done,
    output logic wel_q
);
    always_ff @(posedge clk) begin
        if (hold)
            wel_q <= 1'b0;
        else if (set_req)
            wel_q <= 1'b1;
        else if (clr_req || op_done)
            wel_q <= 1'b0;
    end
endmodule

// File: rtl/fwp_status.sv
module fwp_status
    import fwp_pkg::*;
#(
    parameter int BP_W = 5,
    localparam int STAT_W = BP_W + 2
) (
    input  logic              clk,
    input  logic              hold,
    input  logic              load,
    input  logic [STAT_W-1:0] wdata,
    input  logic              pin_n,
    output logic [STAT_W-1:0] prot_q,
    output logic              writable
);
    always_ff @(posedge clk) begin
        if (hold)
            prot_q <= '0;
        else if (load)
            prot_q <= wdata;
    end

    assign writable = lock_open(prot_q[STAT_W-1 -: 2], pin_n);
endmodule

// File: rtl/fwp_arbiter.sv
module fwp_arbiter
    import fwp_pkg::*;
(
    input  logic             valid,
    input  logic [CMD_W-1:0] code,
    input  logic             wel_q,
    input  logic             pd_q,
    input  logic             lock_busy,
    input  logic             stat_writable,
    output verdict_t         verdict
);
    logic pass;

    always_comb begin
        verdict = '0;
        pass    = 1'b0;
        if (valid) begin
            if (pd_q)
                pass = (code == CMD_PWR_UP);
            else if (!is_known(code))
                pass = 1'b0;
            else if (lock_busy && is_modifying(code))
                pass = 1'b0;
            else if (needs_wel(code) && !wel_q)
                pass = 1'b0;
            else if ((code == CMD_WR_STAT) && !stat_writable)
                pass = 1'b0;
            else
                pass = 1'b1;

            verdict.accept    = pass;
            verdict.reject    = !pass;
            verdict.set_wel   = pass && (code == CMD_WREN);
            verdict.clr_wel   = pass && (code == CMD_WRDI);
            verdict.enter_pd  = pass && (code == CMD_PWR_DN);
            verdict.leave_pd  = pass && (code == CMD_PWR_UP);
            verdict.load_stat = pass && (code == CMD_WR_STAT);
        end
    end
endmodule

// File: rtl/fwp_gate.sv
module fwp_gate
    import fwp_pkg::*;
#(
    parameter int LOCK_CYCLES = 2000,
    parameter int BP_W = 5,
    localparam int STAT_W = BP_W + 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              supply_ok,
    input  logic              wp_n,
    input  logic              cmd_valid,
    input  logic [CMD_W-1:0]  cmd_code,
    input  logic [STAT_W-1:0] stat_wdata,
    input  logic              done_prog,
    input  logic              done_erase,
    input  logic              done_stat,
    output logic              cmd_accept,
    output logic              cmd_reject,
    output logic              wel,
    output logic              pwr_down,
    output logic [STAT_W-1:0] stat_prot
);
    logic     hold;
    logic     lock_busy;
    logic     stat_writable;
    logic     op_done;
    verdict_t verdict;

    assign hold    = rst || !supply_ok;
    assign op_done = done_prog || done_erase || done_stat;

    fwp_lockout #(.LOCK_CYCLES(LOCK_CYCLES)) u_lockout (
        .clk  (clk),
        .hold (hold),
        .busy (lock_busy)
    );

    fwp_arbiter u_arbiter (
        .valid         (cmd_valid),
        .code          (cmd_code),
        .wel_q         (wel),
        .pd_q          (pwr_down),
        .lock_busy     (lock_busy),
        .stat_writable (stat_writable),
        .verdict       (verdict)
    );

    fwp_wel u_wel (
        .clk     (clk),
        .hold    (hold),
        .set_req (verdict.set_wel),
        .clr_req (verdict.clr_wel),
        .op_done (op_done),
        .wel_q   (wel)
    );

    fwp_status #(.BP_W(BP_W)) u_status (
        .clk      (clk),
        .hold     (hold),
        .load     (verdict.load_stat),
        .wdata    (stat_wdata),
        .pin_n    (wp_n),
        .prot_q   (stat_prot),
        .writable (stat_writable)
    );

    always_ff @(posedge clk) begin
        if (hold) begin
            cmd_accept <= 1'b0;
            cmd_reject <= 1'b0;
            pwr_down   <= 1'b0;
        end else begin
            cmd_accept <= verdict.accept;
            cmd_reject <= verdict.reject;
            if (verdict.enter_pd)
                pwr_down <= 1'b1;
            else if (verdict.leave_pd)
                pwr_down <= 1'b0;
        end
    end
endmodule

// File: rtl/fwp_gate_chk.sv
module fwp_gate_chk
    import fwp_pkg::*;
#(
    parameter int BP_W = 5,
    localparam int STAT_W = BP_W + 2
) (
    input logic              clk,
    input logic              rst,
    input logic              supply_ok,
    input logic              cmd_valid,
    input logic [CMD_W-1:0]  cmd_code,
    input logic [STAT_W-1:0] stat_wdata,
    input logic              done_prog,
    input logic              done_erase,
    input logic              done_stat,
    input logic              cmd_accept,
    input logic              cmd_reject,
    input logic              wel,
    input logic              pwr_down,
    input logic [STAT_W-1:0] stat_prot,
    input logic              lock_busy
);
    logic rh;
    logic any_done;
    assign rh       = rst || !supply_ok;
    assign any_done = done_prog || done_erase || done_stat;

    assert_reset_clear_R1: assert property (@(posedge clk)
        rh |=> (!cmd_accept && !cmd_reject && !wel && !pwr_down && stat_prot == '0));

    assert_lockout_wren_R2: assert property (@(posedge clk) disable iff (rh)
        (lock_busy && cmd_valid && cmd_code == CMD_WREN && !pwr_down) |=> cmd_reject);

    assert_wel_rise_R3: assert property (@(posedge clk) disable iff (rh)
        $rose(wel) |-> $past(cmd_valid && cmd_code == CMD_WREN));

    assert_needs_wel_R4: assert property (@(posedge clk) disable iff (rh)
        (cmd_accept && $past(cmd_valid && needs_wel(cmd_code))) |-> $past(wel));

    assert_done_clears_R5: assert property (@(posedge clk) disable iff (rh)
        (any_done && !(cmd_valid && cmd_code == CMD_WREN)) |=> !wel);

    assert_wrdi_R6: assert property (@(posedge clk) disable iff (rh)
        (cmd_valid && cmd_code == CMD_WRDI && !pwr_down) |=> (cmd_accept && !wel));

    assert_pd_only_release_R7: assert property (@(posedge clk) disable iff (rh)
        (pwr_down && cmd_valid && cmd_code != CMD_PWR_UP) |=> cmd_reject);

    assert_hard_lock_R8: assert property (@(posedge clk) disable iff (rh)
        (cmd_valid && cmd_code == CMD_WR_STAT && stat_prot[STAT_W-1]) |=> cmd_reject);

    assert_stat_load_R9: assert property (@(posedge clk) disable iff (rh)
        (cmd_accept && $past(cmd_valid && cmd_code == CMD_WR_STAT)) |->
            (stat_prot == $past(stat_wdata)));

    assert_one_verdict_R10: assert property (@(posedge clk) disable iff (rh)
        !(cmd_accept && cmd_reject));

    assert_verdict_needs_cmd_R10: assert property (@(posedge clk) disable iff (rh)
        (cmd_accept || cmd_reject) |-> $past(cmd_valid));

    assert_stat_only_on_accept_R10: assert property (@(posedge clk) disable iff (rh)
        (!$stable(stat_prot) && $past(!rh)) |-> cmd_accept);
endmodule

bind fwp_gate fwp_gate_chk #(.BP_W(BP_W)) u_fwp_gate_chk (
    .clk        (clk),
    .rst        (rst),
    .supply_ok  (supply_ok),
    .cmd_valid  (cmd_valid),
    .cmd_code   (cmd_code),
    .stat_wdata (stat_wdata),
    .done_prog  (done_prog),
    .done_erase (done_erase),
    .done_stat  (done_stat),
    .cmd_accept (cmd_accept),
    .cmd_reject (cmd_reject),
    .wel        (wel),
    .pwr_down   (pwr_down),
    .stat_prot  (stat_prot),
    .lock_busy  (lock_busy)
);

// File: tb/test_fwp_gate.sv
`timescale 1ns/1ps
module test_fwp_gate;
    localparam int L   = 8;
    localparam int BPW = 5;
    localparam int SW  = BPW + 2;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic          rst = 1'b1, supply_ok = 1'b1, wp_n = 1'b1;
    logic          cmd_valid = 1'b0;
    logic [3:0]    cmd_code = '0;
    logic [SW-1:0] stat_wdata = '0;
    logic          done_prog = 1'b0, done_erase = 1'b0, done_stat = 1'b0;
    logic          cmd_accept, cmd_reject, wel, pwr_down;
    logic [SW-1:0] stat_prot;

    fwp_gate #(.LOCK_CYCLES(L), .BP_W(BPW)) i_fwp_gate (
        .clk(clk), .rst(rst), .supply_ok(supply_ok), .wp_n(wp_n),
        .cmd_valid(cmd_valid), .cmd_code(cmd_code), .stat_wdata(stat_wdata),
        .done_prog(done_prog), .done_erase(done_erase), .done_stat(done_stat),
        .cmd_accept(cmd_accept), .cmd_reject(cmd_reject), .wel(wel),
        .pwr_down(pwr_down), .stat_prot(stat_prot)
    );

    // Count of non-reset clock edges since reset release.
    int n = 0;
    always @(posedge clk) begin
        if (rst || !supply_ok) n <= 0;
        else if (n < 1000000) n <= n + 1;
    end

    int tests = 0, fails = 0;
    bit m_wel = 0, m_pd = 0;
    logic [SW-1:0] m_stat = '0;

    task automatic chk(string tag, int act, int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic issue(int c, logic [SW-1:0] d, bit dp = 0, bit de = 0, bit ds = 0);
        bit valid, lock, acc, modify, needw, known, writable;
        string tag;
        valid = (c >= 0);
        lock  = (n < L);
        cmd_valid  = valid;
        cmd_code   = valid ? 4'(c) : 4'd0;
        stat_wdata = d;
        done_prog = dp; done_erase = de; done_stat = ds;
        known    = valid && c >= 1 && c <= 11;
        modify   = (c == 1) || (c >= 3 && c <= 7);
        needw    = (c >= 3 && c <= 7);
        writable = (m_stat[SW-1 -: 2] == 2'b00) || (m_stat[SW-1 -: 2] == 2'b01 && wp_n);
        tag = "R10";
        acc = 0;
        if (!valid) acc = 0;
        else if (m_pd) begin tag = "R7"; acc = (c == 11); end
        else if (!known) tag = "R11";
        else if (lock && modify) tag = "R2";
        else if (needw && !m_wel) tag = "R4";
        else if (c == 7 && !writable) tag = "R8";
        else begin
            acc = 1;
            tag = (c == 1) ? "R3" : (c == 2) ? "R6" : (c == 7) ? "R9" : "R10";
        end
        @(negedge clk);
        cmd_valid = 0; done_prog = 0; done_erase = 0; done_stat = 0;
        if (dp || de || ds) m_wel = 0;
        if (acc) begin
            case (c)
                1:  m_wel = 1;
                2:  m_wel = 0;
                7:  m_stat = d;
                10: m_pd = 1;
                11: m_pd = 0;
                default: ;
            endcase
        end
        chk({tag, " accept"}, int'(cmd_accept), int'(acc));
        chk({tag, " reject"}, int'(cmd_reject), int'(valid && !acc));
        chk({(dp || de || ds) ? "R5" : tag, " wel"}, int'(wel), int'(m_wel));
        chk("R7 pwr_down", int'(pwr_down), int'(m_pd));
        chk({tag, " status"}, int'(stat_prot), int'(m_stat));
    endtask

    task automatic check_cleared();
        chk("R1 accept", int'(cmd_accept), 0);
        chk("R1 reject", int'(cmd_reject), 0);
        chk("R1 wel", int'(wel), 0);
        chk("R1 pwr_down", int'(pwr_down), 0);
        chk("R1 status", int'(stat_prot), 0);
    endtask

    task automatic power_cycle();
        supply_ok = 0;
        cmd_valid = 1; cmd_code = 4'd1;
        @(negedge clk);
        @(negedge clk);
        check_cleared();
        cmd_valid = 0;
        supply_ok = 1;
        m_wel = 0; m_pd = 0; m_stat = '0;
    endtask

    task automatic wait_lock();
        while (n < L) issue(8, '0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int seq[12] = '{1, 3, 4, 5, 6, 7, 2, 8, 9, 10, 11, 1};
        repeat (3) @(negedge clk);
        check_cleared();
        rst = 0;

        // R2: commands inside and just past the lockout window
        foreach (seq[i]) issue(seq[i], 7'h05);
        issue(3, '0);
        issue(-1, '0, 1, 0, 0);           // R5 completion clears latch
        issue(1, '0, 0, 1, 0);            // R5 write-enable wins over completion
        issue(2, '0);                     // R6

        // R7: every code in power-down, release last
        issue(10, '0);
        for (int c = 0; c < 16; c++) if (c != 11) issue(c, 7'h1F);
        issue(11, '0);

        // R8: hard lock held until a power cycle
        power_cycle();
        wait_lock();
        issue(1, '0);
        issue(7, {2'b10, 5'h15});
        issue(1, '0);
        issue(7, '0);
        power_cycle();
        wait_lock();
        issue(1, '0);
        issue(7, {2'b00, 5'h03});

        // Sweep: lock field x pin x code x latch value
        for (int s = 0; s < 4; s++) begin
            power_cycle();
            wait_lock();
            issue(1, '0);
            issue(7, {2'(s), 5'(s + 1)});
            for (int wp = 0; wp < 2; wp++) begin
                for (int c = 0; c < 16; c++) begin
                    for (int w = 0; w < 2; w++) begin
                        wp_n = wp[0];
                        issue(w ? 1 : 2, '0);
                        issue(c, {2'(s), 5'(c)});
                        if (m_pd) issue(11, '0);
                        if (m_wel) issue(-1, '0, c[0], c[1], c[2]);
                    end
                end
            end
        end

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule